// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Receive FIFO

This block receives 8-bit frames over a clocked synchronous serial link for which it is itself the clock master. A programmable divider of the system clock produces the serial clock output. The block samples the serial data input once per rising edge of that clock and assembles the bits least significant first. Each complete byte goes into a 16-entry receive FIFO. The host drains the FIFO through a valid/ready read port.

Two flags report to the host. The data-ready flag sets once the FIFO fill level reaches a programmable trigger. The overrun flag sets when a frame completes while the FIFO is already full. When an overrun occurs, the offending byte is dropped and the serial clock stops. Reception stays stopped until the host clears the overrun flag. The bytes already stored are kept and can still be read. Two interrupt outputs are derived from the flags under two enable inputs.

Back-pressure on the read port works as follows. `rd_valid` is high whenever the FIFO holds at least one byte, and `rd_data` shows the oldest byte. A byte is removed only in a cycle where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, `rd_valid` and `rd_data` hold. The receive side cannot be stalled: when the FIFO is full, a completed frame becomes an overrun rather than a wait.

Top module: `clksync_rx`

## Requirements
- R1: `sck_out` is low after reset. While `rx_en` is 1 and `ovr_flag` is 0, `sck_out` toggles every `half_period` system clock cycles. Otherwise it is held low. The cycle after `rx_en` falls or `ovr_flag` rises, `sck_out` is 0.
- R2: `sd_in` is sampled at the system clock edge where `sck_out` goes from 0 to 1. Bits fill the byte from bit 0 to bit 7. Every 8 samples form one frame, and a new frame begins on the very next rising edge of `sck_out`.
- R3: A completed frame is written to the FIFO when the FIFO holds fewer than 16 bytes. On the read side, `rd_data` presents bytes in arrival order. A byte is removed on a cycle with `rd_valid` and `rd_ready` both high. `rd_valid` and `rd_data` stay stable while `rd_ready` is low.
- R4: If a frame completes while the FIFO holds 16 bytes, that frame is discarded, `ovr_flag` becomes 1 and `sck_out` stops. The 16 stored bytes are unchanged and can still be read in order.
- R5: `ovr_flag` stays 1 until a cycle with `ovr_clr` = 1 clears it. Reception then resumes, and the next 8 rising edges of `sck_out` form a new frame.
- R6: `rdf_flag` becomes 1 one cycle after the fill level first reaches the trigger level. The trigger is selected by `trig_sel`: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R7: A pulse on `rdf_clr` clears `rdf_flag` only while the fill level is below the trigger level. At or above the trigger, `rdf_clr` has no effect. Without a clear, `rdf_flag` stays 1.
- R8: `irq_rx` is 1 exactly when `rdf_flag` is 1 and `rie` is 1.
- R9: `irq_brk` is 1 exactly when `ovr_flag` is 1 and at least one of `rie` and `reie` is 1.
- R10: After reset, `rd_valid`, `rdf_flag`, `ovr_flag`, `irq_rx` and `irq_brk` are all 0.
- R11: Setting `rx_en` to 0 abandons a partly received frame. After `rx_en` returns to 1, the next 8 sampled bits form a complete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| half_period | input | 8 | System clock cycles per half period of `sck_out` (1 or more) |
| trig_sel | input | 2 | Trigger level select for `rdf_flag` |
| rie | input | 1 | Receive interrupt enable |
| reie | input | 1 | Receive error interrupt enable |
| sd_in | input | 1 | Serial data input |
| sck_out | output | 1 | Serial clock output |
| rd_valid | output | 1 | FIFO holds at least one byte |
| rd_ready | input | 1 | Host accepts the byte shown on `rd_data` |
| rd_data | output | 8 | Oldest stored byte |
| rdf_flag | output | 1 | Data-ready flag |
| rdf_clr | input | 1 | Clear request for `rdf_flag` |
| ovr_flag | output | 1 | Overrun flag |
| ovr_clr | input | 1 | Clear pulse for `ovr_flag` |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_brk | output | 1 | Break/error interrupt on overrun |

## Verification
The assertions assume that `half_period` is nonzero and does not change while the serial clock runs. They also assume that `trig_sel` changes only while the FIFO is empty. The bench programs `half_period` and `trig_sel` only while `rx_en` is 0 and the FIFO has been drained. It changes `sd_in` only while `sck_out` is low, so every sampled bit has been stable for at least one full system clock cycle.

// File: rtl/clksync_rx_pkg.sv
package clksync_rx_pkg;
  // Fill level at which the data-ready flag sets, per selector code.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/clksync_rx_clkgen.sv
module clksync_rx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_period,
  output logic             sck,
  output logic             sample
);
  logic [DIV_W-1:0] cnt_q;
  logic             term;

  assign term   = (cnt_q == half_period - DIV_W'(1));
  assign sample = run && term && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      sck   <= ~sck;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/clksync_rx_shifter.sv
module clksync_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sample,
  input  logic              sd_in,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data
);
  localparam int BC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [BC_W-1:0]   bits_q;

  assign frame_data = {sd_in, sr_q[DATA_W-1:1]};
  assign frame_done = sample && (bits_q == BC_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bits_q <= '0;
    end else if (!enable) begin
      bits_q <= '0;
    end else if (sample) begin
      sr_q   <= frame_data;
      bits_q <= frame_done ? '0 : bits_q + BC_W'(1);
    end
  end
endmodule

// File: rtl/clksync_rx_fifo.sv
module clksync_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW  = $clog2(DEPTH);
  localparam int LVW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic              do_push, do_pop;

  assign full    = (level == LVW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      level  <= '0;
    end else begin
      if (do_push) wptr_q <= bump(wptr_q);
      if (do_pop)  rptr_q <= bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   level <= level + LVW'(1);
        2'b01:   level <= level - LVW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/clksync_rx.sv
module clksync_rx
  import clksync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DIV_W-1:0]  half_period,
  input  logic [1:0]        trig_sel,
  input  logic              rie,
  input  logic              reie,
  input  logic              sd_in,
  output logic              sck_out,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdf_flag,
  input  logic              rdf_clr,
  output logic              ovr_flag,
  input  logic              ovr_clr,
  output logic              irq_rx,
  output logic              irq_brk
);
  localparam int LVW = $clog2(DEPTH + 1);

  logic              run, sample, frame_done, fifo_full, fifo_empty, push;
  logic [DATA_W-1:0] frame_data;
  logic [LVW-1:0]    level;
  logic              at_trig;

  assign run = rx_en && !ovr_flag;

  clksync_rx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .half_period(half_period),
    .sck(sck_out), .sample(sample)
  );

  clksync_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .sample(sample), .sd_in(sd_in),
    .frame_done(frame_done), .frame_data(frame_data)
  );

  assign push = frame_done && !fifo_full;

  clksync_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(frame_data),
    .pop(rd_ready), .head(rd_data), .level(level),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign rd_valid = !fifo_empty;
  assign at_trig  = (level >= LVW'(trig_level(trig_sel, DEPTH)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      rdf_flag <= 1'b0;
    end else begin
      if (frame_done && fifo_full) ovr_flag <= 1'b1;
      else if (ovr_clr)            ovr_flag <= 1'b0;
      rdf_flag <= at_trig || (rdf_flag && !rdf_clr);
    end
  end

  assign irq_rx  = rdf_flag && rie;
  assign irq_brk = ovr_flag && (rie || reie);
endmodule

// File: rtl/clksync_rx_chk.sv
module clksync_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rie,
  input logic              reie,
  input logic              sck_out,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rdf_flag,
  input logic              rdf_clr,
  input logic              ovr_flag,
  input logic              ovr_clr,
  input logic              irq_rx,
  input logic              irq_brk
);
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || ovr_flag) |=> !sck_out); // R1
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag); // R5
  AST_RDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdf_flag && !rdf_clr) |=> rdf_flag); // R7
  AST_IRQ_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rdf_flag && rie)); // R8
  AST_IRQ_BRK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_brk |-> (ovr_flag && (rie || reie))); // R9
  AST_IRQ_BRK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_brk) |-> ($rose(ovr_flag) || $rose(rie) || $rose(reie))); // R9
endmodule

bind clksync_rx clksync_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rie(rie), .reie(reie),
  .sck_out(sck_out), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rdf_flag(rdf_flag), .rdf_clr(rdf_clr), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
  .irq_rx(irq_rx), .irq_brk(irq_brk)
);

// File: tb/test_clksync_rx.sv
module test_clksync_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic [7:0] half_period = 8'd2;
  logic [1:0] trig_sel = 2'd0;
  logic       rie = 1'b0, reie = 1'b0, sd_in = 1'b0;
  logic       sck_out, rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rdf_flag, rdf_clr = 1'b0, ovr_flag, ovr_clr = 1'b0, irq_rx, irq_brk;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clksync_rx i_clksync_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .half_period(half_period),
    .trig_sel(trig_sel), .rie(rie), .reie(reie), .sd_in(sd_in),
    .sck_out(sck_out), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rdf_flag(rdf_flag), .rdf_clr(rdf_clr), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
    .irq_rx(irq_rx), .irq_brk(irq_brk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sd_in = b[i];
      do @(negedge clk); while (!sck_out);
      do @(negedge clk); while (sck_out);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic pop_check(input logic [7:0] exp, input string req);
    check(rd_valid == 1'b1, req, rd_valid, 1);
    check(rd_data == exp, req, rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse_rdf_clr();
    rdf_clr = 1'b1; @(negedge clk); rdf_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    check(sck_out == 0, "R1 reset sck", sck_out, 0);
    check(rd_valid == 0 && rdf_flag == 0 && ovr_flag == 0, "R10 reset flags",
          {rd_valid, rdf_flag, ovr_flag}, 0);
    check(irq_rx == 0 && irq_brk == 0, "R10 reset irq", {irq_rx, irq_brk}, 0);
  endtask

  task automatic t_clock(input logic [7:0] hp);
    int period;
    half_period = hp;
    rx_en = 1'b1;
    do @(negedge clk); while (!sck_out);
    do @(negedge clk); while (sck_out);
    period = 0;
    do begin @(negedge clk); period++; end while (!sck_out);
    do begin @(negedge clk); period++; end while (sck_out);
    check(period == 2 * hp, "R1 sck period", period, 2 * hp);
    rx_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (sck_out) begin check(0, "R1 idle low", 1, 0); break; end
      @(negedge clk);
    end
    check(sck_out == 0, "R1 idle low", sck_out, 0);
    half_period = 8'd2;
  endtask

  task automatic t_order();
    rx_en = 1'b1;
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h01);
    rx_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(rd_valid == 1 && rd_data == 8'hA5, "R3 hold under back-pressure", rd_data, 8'hA5);
      @(negedge clk);
    end
    pop_check(8'hA5, "R2 lsb first");
    pop_check(8'h3C, "R3 order");
    pop_check(8'h01, "R2 back-to-back frame");
    check(rd_valid == 0, "R3 empty after drain", rd_valid, 0);
    pulse_rdf_clr();
  endtask

  task automatic t_rdf();
    trig_sel = 2'd1;
    rie = 1'b0;
    rx_en = 1'b1;
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    check(rdf_flag == 0, "R6 below trigger 4", rdf_flag, 0);
    send_byte(8'h44);
    rx_en = 1'b0;
    check(rdf_flag == 1, "R6 at trigger 4", rdf_flag, 1);
    check(irq_rx == 0, "R8 rie off", irq_rx, 0);
    rie = 1'b1; @(negedge clk);
    check(irq_rx == 1, "R8 rie on", irq_rx, 1);
    pulse_rdf_clr();
    check(rdf_flag == 1, "R7 clear ignored at trigger", rdf_flag, 1);
    pop_check(8'h11, "R3 rdf pop");
    pulse_rdf_clr();
    check(rdf_flag == 0, "R7 clear below trigger", rdf_flag, 0);
    check(irq_rx == 0, "R8 follows flag", irq_rx, 0);
    pop_check(8'h22, "R3 rdf pop"); pop_check(8'h33, "R3 rdf pop"); pop_check(8'h44, "R3 rdf pop");
    trig_sel = 2'd0;
    rie = 1'b0;
    rx_en = 1'b1;
    send_byte(8'h9E);
    rx_en = 1'b0;
    check(rdf_flag == 1, "R6 trigger 1", rdf_flag, 1);
    pop_check(8'h9E, "R6 trigger 1 data");
    pulse_rdf_clr();
  endtask

  task automatic t_overrun();
    trig_sel = 2'd3;
    rx_en = 1'b1;
    for (int i = 0; i < 13; i++) send_byte(8'(8'h40 + i));
    check(rdf_flag == 0, "R6 below trigger 14", rdf_flag, 0);
    send_byte(8'h4D);
    check(rdf_flag == 1, "R6 at trigger 14", rdf_flag, 1);
    send_byte(8'h4E); send_byte(8'h4F);
    check(ovr_flag == 0, "R4 full no overrun yet", ovr_flag, 0);
    send_byte(8'hEE);
    check(ovr_flag == 1, "R4 overrun set", ovr_flag, 1);
    for (int i = 0; i < 20; i++) begin
      if (sck_out) begin check(0, "R4 clock stopped", 1, 0); break; end
      @(negedge clk);
    end
    check(sck_out == 0, "R4 clock stopped", sck_out, 0);
    check(irq_brk == 0, "R9 no enables", irq_brk, 0);
    reie = 1'b1; @(negedge clk);
    check(irq_brk == 1, "R9 reie", irq_brk, 1);
    reie = 1'b0; rie = 1'b1; @(negedge clk);
    check(irq_brk == 1, "R9 rie", irq_brk, 1);
    rie = 1'b0; @(negedge clk);
    for (int i = 0; i < 16; i++) pop_check(8'(8'h40 + i), "R4 stored bytes kept");
    check(rd_valid == 0, "R4 overrun frame discarded", rd_valid, 0);
    check(ovr_flag == 1, "R5 sticky", ovr_flag, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    check(ovr_flag == 0, "R5 cleared", ovr_flag, 0);
    send_byte(8'hC3);
    rx_en = 1'b0;
    @(negedge clk);
    pop_check(8'hC3, "R5 resumed");
    pulse_rdf_clr();
    trig_sel = 2'd0;
  endtask

  task automatic t_abort();
    rx_en = 1'b1;
    send_bits(8'hFF, 3);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_valid == 0, "R11 partial not stored", rd_valid, 0);
    rx_en = 1'b1;
    send_byte(8'h5A);
    rx_en = 1'b0;
    @(negedge clk);
    pop_check(8'h5A, "R11 fresh frame");
    check(rd_valid == 0, "R11 single frame", rd_valid, 0);
    pulse_rdf_clr();
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clock(8'd2);
    t_clock(8'd3);
    t_order();
    t_rdf();
    t_overrun();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule